// File: doc/BRIEF.md
# Bus-Controlled Clock-Cycle Timer

This block is a small APB slave that software uses to time stretches of code in clock cycles. It holds a 32-bit control word and a 32-bit cycle count. Two bits of the control word drive the count: one makes it advance by one on every clock, the other forces it to zero. Software starts the timer, runs the code under test, stops the timer and then reads the count back. Because the control word reads back exactly as written, software can also change a single bit with a read-modify-write.

The count is changed only by its own increment and clear logic. The bus can read it but never write it, so the count register has a single driver. The block decodes a 1024-byte window whose base address is a parameter. The base must lie in the upper half of the 32-bit address space and be aligned to the window size. Transfers complete without wait states and never signal an error.

Top module: `apb_cycle_timer`

## Requirements
- R1: After PRESETn is low at a clock edge, the control word and the count both read as zero.
- R2: Offset 0x0 holds the control word. Every write in the access phase replaces all 32 bits, and a read at 0x0 returns the last value written.
- R3: While control bit 0 is 1 and bit 1 is 0, the count rises by one on every clock edge, wrapping modulo 2^32. While both bits are 0, the count holds. A new control word takes effect on the first clock edge after the write's access edge.
- R4: While control bit 1 is 1, the count is zero from the next edge onward, whatever bit 0 holds. The clear takes priority over the increment.
- R5: A read at offset 0x4 returns the count as it stands in that access cycle.
- R6: A write to offset 0x4 is ignored: neither the count nor the control word changes.
- R7: Inside the window, every offset other than 0x0 and 0x4, including unaligned offsets, reads as zero, and writes to these offsets change nothing.
- R8: A transfer to an address outside the window from the base through base+0x3FF writes nothing and reads zero.
- R9: A write is taken only when PSEL, PENABLE and PWRITE are all high. A setup phase on its own, or a read, leaves the control word unchanged.
- R10: In every access phase, PREADY is 1 and PSLVERR is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| PCLK | input | 1 | Bus and counter clock |
| PRESETn | input | 1 | Active-low synchronous reset |
| PSEL | input | 1 | Slave select |
| PENABLE | input | 1 | Access-phase marker |
| PWRITE | input | 1 | 1 for a write, 0 for a read |
| PADDR | input | 32 | Byte address |
| PWDATA | input | 32 | Write data |
| PRDATA | output | 32 | Read data; zero when no read to a mapped register is in progress |
| PREADY | output | 1 | Always 1 (no wait states) |
| PSLVERR | output | 1 | Always 0 |

## Verification
The counting function is driven with directed control words: run only, hold, clear only, and clear together with run. These separate the increment path from the hold path and show which path wins when both bits are set. Seeded random traffic then mixes control words whose upper bits are random with count reads at irregular idle gaps. This exposes off-by-one errors in the cycle when a new control word takes effect. Writes to the count offset, to unmapped and unaligned offsets, to addresses outside the window, and setup phases that never reach the access phase each check that a stray transfer cannot disturb state that a later read brings out.

// File: rtl/cyc_ctr_pkg.sv
package cyc_ctr_pkg;

   // byte offsets of the two mapped registers inside the window
   localparam int unsigned OFS_CTRL  = 32'h0;
   localparam int unsigned OFS_COUNT = 32'h4;

   // control-word bit positions decoded by the counter datapath
   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_CLR_BIT = 1;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_COUNT = 2'd2
   } reg_sel_e;

endpackage

// File: rtl/cyc_ctr_decode.sv
module cyc_ctr_decode
   import cyc_ctr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned WIN_BYTES = 1024,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8F00_0000
) (
   input  logic [ADDR_W-1:0] paddr,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   output logic              win_hit,
   output reg_sel_e          reg_sel,
   output logic              ctrl_wr
);

   localparam int unsigned OFS_W = $clog2(WIN_BYTES);
   localparam int unsigned TAG_W = ADDR_W - OFS_W;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:OFS_W];
   localparam logic [OFS_W-1:0] CTRL_OFS  = OFS_W'(OFS_CTRL);
   localparam logic [OFS_W-1:0] COUNT_OFS = OFS_W'(OFS_COUNT);

   generate
      if ((1 << OFS_W) != WIN_BYTES) begin : g_bad_win
         $error("WIN_BYTES must be a power of two");
      end
      if (WIN_BYTES < 8) begin : g_small_win
         $error("WIN_BYTES must cover both registers");
      end
      if (BASE_ADDR[ADDR_W-1] != 1'b1) begin : g_bad_base
         $error("BASE_ADDR must lie in the upper half of the address space");
      end
      if (BASE_ADDR[OFS_W-1:0] != '0) begin : g_unaligned
         $error("BASE_ADDR must be aligned to WIN_BYTES");
      end
   endgenerate

   logic [OFS_W-1:0] ofs;

   assign win_hit = (paddr[ADDR_W-1:OFS_W] == BASE_TAG);
   assign ofs     = paddr[OFS_W-1:0];

   always_comb begin
      reg_sel = SEL_NONE;
      if (win_hit) begin
         if (ofs == CTRL_OFS)       reg_sel = SEL_CTRL;
         else if (ofs == COUNT_OFS) reg_sel = SEL_COUNT;
      end
   end

   // writes land only in the access phase; the count offset is never writable
   assign ctrl_wr = psel && penable && pwrite && (reg_sel == SEL_CTRL);

endmodule

// File: rtl/cyc_ctr_ctrl_reg.sv
module cyc_ctr_ctrl_reg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl
);

   generate
      if (DATA_W < 2) begin : g_narrow
         $error("DATA_W must hold the run and clear bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ctrl <= '0;
      else if (wr_en) ctrl <= wdata;
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctrl)); // R9

endmodule

// File: rtl/cyc_ctr_count.sv
module cyc_ctr_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] count_inc;
   logic [CNT_W-1:0] count_nxt;

   assign count_inc = count + STEP;

   // clear wins over increment; neither bit set holds the value
   always_comb begin
      unique casez ({clr, run})
         2'b1?:   count_nxt = '0;
         2'b01:   count_nxt = count_inc;
         default: count_nxt = count;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count_nxt;
   end

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(count)); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr) |=> (count == $past(count) + STEP)); // R3
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R4

endmodule

// File: rtl/apb_cycle_timer.sv
module apb_cycle_timer
   import cyc_ctr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned WIN_BYTES = 1024,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h8F00_0000
) (
   input  logic              PCLK,
   input  logic              PRESETn,
   input  logic              PSEL,
   input  logic              PENABLE,
   input  logic              PWRITE,
   input  logic [ADDR_W-1:0] PADDR,
   input  logic [DATA_W-1:0] PWDATA,
   output logic [DATA_W-1:0] PRDATA,
   output logic              PREADY,
   output logic              PSLVERR
);

   generate
      if (CNT_W > DATA_W) begin : g_wide_cnt
         $error("CNT_W must not exceed DATA_W");
      end
   endgenerate

   logic              win_hit;
   reg_sel_e          reg_sel;
   logic              ctrl_wr;
   logic [DATA_W-1:0] ctrl;
   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] count_ext;
   logic [DATA_W-1:0] rd_mux;
   logic              rd_act;

   cyc_ctr_decode #(
      .ADDR_W   (ADDR_W),
      .WIN_BYTES(WIN_BYTES),
      .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .paddr  (PADDR),
      .psel   (PSEL),
      .penable(PENABLE),
      .pwrite (PWRITE),
      .win_hit(win_hit),
      .reg_sel(reg_sel),
      .ctrl_wr(ctrl_wr)
   );

   cyc_ctr_ctrl_reg #(
      .DATA_W(DATA_W)
   ) u_ctrl (
      .clk  (PCLK),
      .rst_n(PRESETn),
      .wr_en(ctrl_wr),
      .wdata(PWDATA),
      .ctrl (ctrl)
   );

   cyc_ctr_count #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk  (PCLK),
      .rst_n(PRESETn),
      .run  (ctrl[CTRL_RUN_BIT]),
      .clr  (ctrl[CTRL_CLR_BIT]),
      .count(count)
   );

   generate
      if (CNT_W == DATA_W) begin : g_cnt_full
         assign count_ext = count;
      end else begin : g_cnt_pad
         assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
      end
   endgenerate

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL:  rd_mux = ctrl;
         SEL_COUNT: rd_mux = count_ext;
         default:   rd_mux = '0;
      endcase
   end

   assign rd_act  = PSEL && !PWRITE;
   assign PRDATA  = rd_act ? rd_mux : '0;
   assign PREADY  = 1'b1;
   assign PSLVERR = 1'b0;

   AST_OUTSIDE_READS_ZERO: assert property (@(posedge PCLK) disable iff (!PRESETn)
      (PSEL && !PWRITE && !win_hit) |-> (PRDATA == '0)); // R8

endmodule

// File: tb/apb_cycle_timer_bench.sv
module apb_cycle_timer_bench;

   localparam logic [31:0] BASE = 32'h8F00_0000;
   localparam int WATCHDOG = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0;
   logic        penable = 1'b0;
   logic        pwrite = 1'b0;
   logic [31:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic        pslverr;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   // reference state built from the requirements
   logic [31:0] m_ctrl = '0;
   logic [31:0] m_cnt  = '0;

   always #4 clk = ~clk;

   apb_cycle_timer #(.BASE_ADDR(BASE)) u_apb_cycle_timer (
      .PCLK(clk), .PRESETn(rst_n), .PSEL(psel), .PENABLE(penable),
      .PWRITE(pwrite), .PADDR(paddr), .PWDATA(pwdata), .PRDATA(prdata),
      .PREADY(pready), .PSLVERR(pslverr)
   );

   function automatic bit in_win(input logic [31:0] a);
      return a[31:10] == BASE[31:10];
   endfunction

   function automatic logic [31:0] exp_read(input logic [31:0] a);
      if (!in_win(a))          return '0;  // R8
      if (a[9:0] == 10'h000)   return m_ctrl; // R2
      if (a[9:0] == 10'h004)   return m_cnt;  // R5
      return '0;                              // R7
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl <= '0;
         m_cnt  <= '0;
      end else begin
         if (psel && penable && pwrite && in_win(paddr) && paddr[9:0] == 10'h000)
            m_ctrl <= pwdata;
         if (m_ctrl[1])      m_cnt <= '0;
         else if (m_ctrl[0]) m_cnt <= m_cnt + 32'd1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   // each task starts and ends just after a falling edge
   task automatic apb_write(input logic [31:0] a, input logic [31:0] d);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #1;
      chk("R10 ready", {31'd0, pready}, 32'd1);
      chk("R10 slverr", {31'd0, pslverr}, 32'd0);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [31:0] a, input string req);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1;
      chk(req, prdata, exp_read(a));
      chk("R10 ready", {31'd0, pready}, 32'd1);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   logic [31:0] snap;

   initial begin
      void'($urandom(32'd20240611));
      idle(4);
      #1;
      chk("R1 idle rdata", prdata, 32'd0);
      rst_n = 1'b1;
      idle(1);
      apb_read(BASE + 32'h0, "R1 ctrl after reset");
      apb_read(BASE + 32'h4, "R1 count after reset");
      chk("R1 count zero", exp_read(BASE + 32'h4), 32'd0);

      // run, then stop and verify hold
      apb_write(BASE, 32'h1);
      idle(9);
      apb_write(BASE, 32'h0);
      apb_read(BASE + 32'h4, "R3 count after run");
      snap = m_cnt;
      chk("R3 run advanced", {31'd0, snap > 32'd9}, 32'd1);
      idle(5);
      apb_read(BASE + 32'h4, "R3 hold while stopped");
      chk("R3 hold value", m_cnt, snap);

      // full-word replacement
      apb_write(BASE, 32'hA5A5_0000);
      apb_read(BASE, "R2 full word readback");
      apb_write(BASE, 32'h1);
      apb_read(BASE, "R2 upper bits zeroed");

      // clear alone and clear together with run
      apb_write(BASE, 32'h2);
      idle(3);
      apb_read(BASE + 32'h4, "R4 clear");
      apb_write(BASE, 32'h3);
      idle(6);
      apb_read(BASE + 32'h4, "R4 clear beats run");
      chk("R4 zero", m_cnt, 32'd0);

      // write to the count offset is ignored
      apb_write(BASE, 32'h0);
      apb_write(BASE + 32'h4, 32'hFFFF_FFF0);
      apb_read(BASE + 32'h4, "R6 count unchanged");
      apb_read(BASE, "R6 ctrl unchanged");

      // unmapped and unaligned offsets
      apb_write(BASE + 32'h8, 32'h1);
      apb_write(BASE + 32'h1, 32'h1);
      apb_read(BASE + 32'h0, "R7 ctrl untouched");
      apb_read(BASE + 32'h8, "R7 unmapped reads zero");
      apb_read(BASE + 32'h3FC, "R7 top offset reads zero");
      apb_read(BASE + 32'h5, "R7 unaligned reads zero");

      // outside the window
      apb_write(BASE + 32'h400, 32'h1);
      apb_write(BASE - 32'h400, 32'h1);
      apb_read(BASE, "R8 ctrl untouched");
      apb_read(BASE + 32'h400, "R8 above window reads zero");
      apb_read(32'h0F00_0004, "R8 low half reads zero");

      // setup phase without access must not write
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = BASE; pwdata = 32'h1;
      idle(1);
      psel = 1'b0; pwrite = 1'b0;
      idle(2);
      apb_read(BASE, "R9 setup-only write ignored");
      chk("R9 ctrl stays zero", m_ctrl, 32'd0);

      // seeded random traffic
      for (int i = 0; i < 3000; i++) begin
         int unsigned kind;
         logic [31:0] r;
         kind = $urandom_range(0, 9);
         r = $urandom;
         case (kind)
            0, 1: apb_write(BASE, {r[31:2], 2'($urandom_range(0, 3))});
            2:    apb_write(BASE, {r[31:2], 2'b01});
            3:    apb_read(BASE + 32'h4, "R3 random count");
            4:    apb_read(BASE + 32'h4, "R5 random count");
            5:    apb_read(BASE, "R2 random ctrl");
            6:    apb_write(BASE + 32'h4, r);
            7:    apb_write({1'b0, r[30:0]}, r);
            8:    apb_read(BASE + {22'd0, r[9:2], 2'b00}, "R7 random offset");
            default: idle($urandom_range(0, 20));
         endcase
      end
      apb_read(BASE + 32'h4, "R5 final count");
      apb_read(BASE, "R2 final ctrl");
      finish_run();
   end

endmodule